// File: doc/BRIEF.md
# Hybrid Two-Component Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side, and each keeps its own table of two-bit saturating counters. Component A is normally a local two-level predictor: it keeps a per-branch shift register of recent outcomes, and that register indexes A's counters. Component B is a global two-level predictor: a single shift register records the outcomes of all branches, and that register indexes B's counters. A parameter can instead make component A a second global predictor that uses only the most recent few bits of the global history. A third table of two-bit counters, the chooser, is indexed by the branch address. Its high bit decides which component's prediction is passed on as the final answer.

A lookup enters on a valid/ready request stream that carries the branch address. The answer leaves on a valid/ready response stream that carries the final prediction and both component predictions. The front end keeps the two component predictions with the branch. When the branch resolves, it returns them on a plain single-cycle update strobe together with the real outcome, so training needs no second table read. The response stage holds one entry. A request is accepted when no response is waiting or when the waiting response is being taken in the same cycle. While the consumer holds `rsp_ready` low, the response stays unchanged and no new request is accepted. Updates are always accepted and have no handshake.

Top module: `hbp_top`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Every component counter starts at 1 (weak not-taken), every chooser counter starts at 2 (weak, favouring B), and every history register is all zeros. The first lookup therefore returns 0 for A, for B and for the final prediction.
- R2: Each counter is two bits wide and saturates at 0 and 3. A taken outcome increments it and a not-taken outcome decrements it. A component predicts taken when bit 1 of its selected counter is 1.
- R3: With `PAIR_MODE`=0, component A's counter is selected by the local history of the branch. The local history is the last `LHIST_W` outcomes recorded at the history slot given by the low `IDX_W` bits of the PC, with the newest outcome in bit 0.
- R4: Component B's counter is selected by the global history, which holds the last `GHIST_W` resolved outcomes of all branches with the newest outcome in bit 0.
- R5: The final prediction is B's prediction when bit 1 of the chooser counter at the low `IDX_W` PC bits is 1. Otherwise it is A's prediction.
- R6: The chooser counter at the low `IDX_W` bits of `upd_pc` changes only when `upd_pred_a` differs from `upd_pred_b`. It is incremented when B matched the outcome and decremented when A matched the outcome.
- R7: Every update trains both components with `upd_taken`, whichever component was selected.
- R8: Each response carries A's prediction on `rsp_pred_a` and B's prediction on `rsp_pred_b`, both taken from the same table state as the final prediction.
- R9: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1, and its response appears with `rsp_valid`=1 at the next edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields do not change.
- R10: With `PAIR_MODE`=1, component A is a global predictor whose counter is selected by the newest `SHORT_W` bits of the global history.
- R11: An update trains the counters selected by the histories as they stood before that update. It then shifts `upd_taken` into the global history and, with `PAIR_MODE`=0, into the local history slot of `upd_pc`. A lookup made after the update sees the new state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_pc | input | PC_W | Branch address to look up |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_taken | output | 1 | Final prediction, 1 = taken |
| rsp_pred_a | output | 1 | Component A prediction |
| rsp_pred_b | output | 1 | Component B prediction |
| upd_valid | input | 1 | Resolved branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_pred_a | input | 1 | A's prediction returned with the lookup |
| upd_pred_b | input | 1 | B's prediction returned with the lookup |

## Verification
One instance is built with each `PAIR_MODE`, and both run on the same stimulus. The first pattern is a loop pattern (taken three times, then not taken) swept over all sixteen PC slots. This pattern separates local from global indexing, because the local histories differ from slot to slot while the global history is shared. A strictly alternating branch drives the two components apart, so the chooser has to move and the final answer changes hands. Long runs of taken followed by not-taken outcomes push counters into both saturation limits. Addresses that differ only above the index bits check that those bits are ignored. A stalled response stream shows that the held response stays unchanged and that the request waiting behind it is answered from the correct state once the stall ends.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'b01;
  localparam ctr2_t CTR_WEAK_T  = 2'b10;

  // saturating step: up moves toward 3, down toward 0
  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/hbp_ctr_table.sv
module hbp_ctr_table
  import hbp_pkg::*;
#(
  parameter int    IDX_W = 4,
  parameter ctr2_t INIT  = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_hi,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t ctr_q [DEPTH];

  assign rd_hi = ctr_q[rd_idx][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= INIT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_up);
    end
  end
endmodule

// File: rtl/hbp_hist_table.sv
module hbp_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic [HIST_W-1:0] wr_hist,
  input  logic              wr_en,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  assign rd_hist = hist_q[rd_idx];
  assign wr_hist = hist_q[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= {hist_q[wr_idx][HIST_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/hbp_top.sv
module hbp_top
  import hbp_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int IDX_W     = 4,
  parameter int LHIST_W   = 4,
  parameter int GHIST_W   = 4,
  parameter int SHORT_W   = 2,
  parameter int PAIR_MODE = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PC_W-1:0] req_pc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  output logic            rsp_pred_a,
  output logic            rsp_pred_b,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_pred_a,
  input  logic            upd_pred_b
);
  localparam int AIDX_W = (PAIR_MODE == 0) ? LHIST_W : SHORT_W;

  logic [IDX_W-1:0]   rd_slot, wr_slot;
  logic [GHIST_W-1:0] ghist_q;
  logic [AIDX_W-1:0]  a_rd_idx, a_wr_idx;
  logic               a_hi, b_hi, sel_b;
  logic               accept;
  logic               unused_pc_hi;

  assign rd_slot      = req_pc[IDX_W-1:0];
  assign wr_slot      = upd_pc[IDX_W-1:0];
  assign unused_pc_hi = ^{req_pc, upd_pc};

  // global outcome history, newest in bit 0
  always_ff @(posedge clk) begin
    if (!rst_n) ghist_q <= '0;
    else if (upd_valid) ghist_q <= {ghist_q[GHIST_W-2:0], upd_taken};
  end

  generate
    if (PAIR_MODE == 0) begin : g_local
      logic [LHIST_W-1:0] lh_rd, lh_wr;
      hbp_hist_table #(.IDX_W(IDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_slot),
        .rd_hist (lh_rd),
        .wr_idx  (wr_slot),
        .wr_hist (lh_wr),
        .wr_en   (upd_valid),
        .wr_bit  (upd_taken)
      );
      assign a_rd_idx = lh_rd;
      assign a_wr_idx = lh_wr;
    end else begin : g_short
      assign a_rd_idx = ghist_q[SHORT_W-1:0];
      assign a_wr_idx = ghist_q[SHORT_W-1:0];
    end
  endgenerate

  hbp_ctr_table #(.IDX_W(AIDX_W), .INIT(CTR_WEAK_NT)) u_comp_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (a_rd_idx),
    .rd_hi  (a_hi),
    .wr_en  (upd_valid),
    .wr_idx (a_wr_idx),
    .wr_up  (upd_taken)
  );

  hbp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_NT)) u_comp_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (ghist_q),
    .rd_hi  (b_hi),
    .wr_en  (upd_valid),
    .wr_idx (ghist_q),
    .wr_up  (upd_taken)
  );

  // chooser: moves only on disagreement, toward B when B was right
  hbp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_T)) u_chooser (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (rd_slot),
    .rd_hi  (sel_b),
    .wr_en  (upd_valid && (upd_pred_a != upd_pred_b)),
    .wr_idx (wr_slot),
    .wr_up  (upd_pred_b == upd_taken)
  );

  // one-entry response stage
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_pred_a <= 1'b0;
      rsp_pred_b <= 1'b0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_taken  <= sel_b ? b_hi : a_hi;
      rsp_pred_a <= a_hi;
      rsp_pred_b <= b_hi;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/hbp_chk.sv
module hbp_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic rsp_taken,
  input logic rsp_pred_a,
  input logic rsp_pred_b
);
  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

  p_accept_gives_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_taken)
      && $stable(rsp_pred_a) && $stable(rsp_pred_b));

  p_rsp_from_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  p_agree_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_pred_a == rsp_pred_b) |-> rsp_taken == rsp_pred_a);

  p_pick_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_taken == rsp_pred_a) || (rsp_taken == rsp_pred_b));
endmodule

bind hbp_top hbp_chk u_hbp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_taken  (rsp_taken),
  .rsp_pred_a (rsp_pred_a),
  .rsp_pred_b (rsp_pred_b)
);

// File: tb/test_hbp_top.sv
module test_hbp_top;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, rsp_ready = 1'b1, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [PC_W-1:0] req_pc = '0, upd_pc = '0;
  logic ua0 = 1'b0, ub0 = 1'b0, ua1 = 1'b0, ub1 = 1'b0;
  logic rr0, rv0, rt0, ra0, rb0;
  logic rr1, rv1, rt1, ra1, rb1;

  hbp_top #(.PAIR_MODE(0)) i_hbp_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rr0), .req_pc(req_pc),
    .rsp_valid(rv0), .rsp_ready(rsp_ready), .rsp_taken(rt0), .rsp_pred_a(ra0), .rsp_pred_b(rb0),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_pred_a(ua0), .upd_pred_b(ub0));

  hbp_top #(.PAIR_MODE(1)) i_hbp_top_g2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rr1), .req_pc(req_pc),
    .rsp_valid(rv1), .rsp_ready(rsp_ready), .rsp_taken(rt1), .rsp_pred_a(ra1), .rsp_pred_b(rb1),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_pred_a(ua1), .upd_pred_b(ub1));

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int lcnt[16], lh[16], gcnt0[16], ch0[16];
  int acnt[4], gcnt1[16], ch1[16];
  int gh;

  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_pred(int pc, output int e0a, e0b, e0t, e1a, e1b, e1t);
    int s = pc & 15;
    e0a = lcnt[lh[s]] >> 1;
    e0b = gcnt0[gh] >> 1;
    e0t = (ch0[s] >= 2) ? e0b : e0a;
    e1a = acnt[gh & 3] >> 1;
    e1b = gcnt1[gh] >> 1;
    e1t = (ch1[s] >= 2) ? e1b : e1a;
  endtask

  task automatic step(int pc, bit t);
    int e0a, e0b, e0t, e1a, e1b, e1t, s;
    s = pc & 15;
    expect_pred(pc, e0a, e0b, e0t, e1a, e1b, e1t);
    @(negedge clk);
    req_valid = 1'b1; req_pc = PC_W'(pc);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "rsp_valid", int'(rv0), 1);
    check("R2 R3 R7 R11", "local pred_a", int'(ra0), e0a);
    check("R2 R4 R7 R8", "global pred_b", int'(rb0), e0b);
    check("R5 R6", "final mode0", int'(rt0), e0t);
    check("R10", "short pred_a", int'(ra1), e1a);
    check("R4 R8", "pred_b mode1", int'(rb1), e1b);
    check("R5 R6", "final mode1", int'(rt1), e1t);
    upd_valid = 1'b1; upd_pc = PC_W'(pc); upd_taken = t;
    ua0 = ra0; ub0 = rb0; ua1 = ra1; ub1 = rb1;
    @(negedge clk);
    upd_valid = 1'b0;
    lcnt[lh[s]] = sat(lcnt[lh[s]], t);
    gcnt0[gh] = sat(gcnt0[gh], t);
    if (e0a != e0b) ch0[s] = sat(ch0[s], e0b == int'(t));
    lh[s] = ((lh[s] << 1) | int'(t)) & 15;
    acnt[gh & 3] = sat(acnt[gh & 3], t);
    gcnt1[gh] = sat(gcnt1[gh], t);
    if (e1a != e1b) ch1[s] = sat(ch1[s], e1b == int'(t));
    gh = ((gh << 1) | int'(t)) & 15;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e0a, e0b, e0t, e1a, e1b, e1t;
    logic ht, ha, hb;
    for (int i = 0; i < 16; i++) begin
      lcnt[i] = 1; lh[i] = 0; gcnt0[i] = 1; ch0[i] = 2; gcnt1[i] = 1; ch1[i] = 2;
    end
    for (int i = 0; i < 4; i++) acnt[i] = 1;
    gh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "rsp_valid after reset", int'(rv0), 0);
    check("R1", "req_ready after reset", int'(rr0), 1);
    check("R1", "rsp_valid mode1", int'(rv1), 0);
    @(negedge clk);
    req_valid = 1'b1; req_pc = 16'h0006;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", "first pred_a", int'(ra0), 0);
    check("R1", "first pred_b", int'(rb0), 0);
    check("R1", "first final", int'(rt0), 0);
    @(negedge clk);

    // loop pattern across all slots
    for (int p = 0; p < 16; p++)
      for (int k = 0; k < 12; k++) step(p, (k % 4) != 3);
    // alternating branch pulls the components apart
    for (int k = 0; k < 20; k++) step(5, k[0]);
    // saturation both ways
    for (int k = 0; k < 8; k++) step(9, 1'b1);
    for (int k = 0; k < 8; k++) step(9, 1'b0);
    // upper address bits alias onto the same slot
    for (int k = 0; k < 10; k++) step(16'h1230 | (k % 3), (k % 3) == 0);
    for (int k = 0; k < 10; k++) step(16'h8003, 1'b1);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_pc = 16'h0003;
    @(negedge clk);
    ht = rt0; ha = ra0; hb = rb0;
    req_pc = 16'h0007;
    check("R9", "rsp_valid under stall", int'(rv0), 1);
    check("R9", "req_ready under stall", int'(rr0), 0);
    repeat (3) @(negedge clk);
    check("R9", "held taken", int'(rt0), int'(ht));
    check("R9", "held pred_a", int'(ra0), int'(ha));
    check("R9", "held pred_b", int'(rb0), int'(hb));
    check("R9", "still stalled ready", int'(rr0), 0);
    expect_pred(7, e0a, e0b, e0t, e1a, e1b, e1t);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "queued rsp_valid", int'(rv0), 1);
    check("R9 R8", "queued pred_a", int'(ra0), e0a);
    check("R9 R8", "queued pred_b", int'(rb0), e0b);
    check("R9 R5", "queued final", int'(rt0), e0t);
    @(negedge clk);
    check("R9", "drained rsp_valid", int'(rv0), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule